// File: doc/BRIEF.md
# March Test Self-Test Controller

This controller drives a one-bit-wide RAM through a chosen march algorithm. It then judges each read against the value the algorithm expects at that point. An algorithm is an ordered set of elements. Each element has an address direction and a list of up to six operations. An operation either writes 0 or 1, or reads a cell and expects 0 or 1.

Within an element, the controller finishes the whole operation list on one cell before it moves to the next address. It issues one memory operation per clock. Four algorithms are held in a fixed table inside the block, and a two-bit input selects one of them when the run starts.

For retention testing, a wait of a programmable number of idle cycles can be placed after the two elements that fill the array with a known value. This lets leakage act before the next read. The first miscompare is recorded as three values: the address, the element index and the operation index. A control input decides whether the run stops at that miscompare or goes on to the end. A one-cycle done pulse closes the run.

Top module: `march_bist`

## Requirements
- R1: After reset, busy, done and fail are low, and neither mem_we nor mem_re is asserted until a run is started.
- R2: A high start while idle begins a run, and busy is high from the next cycle until done. A start seen while busy has no effect: the access sequence and the run length stay unchanged.
- R3: Exactly one memory operation is issued per active cycle, and mem_we and mem_re are never high together. Each element applies all of its operations to one address before moving on. An ascending element visits 0 to N-1 and a descending element visits N-1 to 0. An element of unspecified order runs ascending.
- R4: algo_sel = 0 runs MATS+: up(w0); up(r0,w1); down(r1,w0). That is 5N operations.
- R5: algo_sel = 1 runs March C-: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). That is 10N operations.
- R6: algo_sel = 2 runs March A: up(w0); up(r0,w1,w0,w1); up(r1,w0,w1); down(r1,w0,w1,w0); down(r0,w1,w0). That is 15N operations.
- R7: algo_sel = 3 runs March B. It is March A with element 1 replaced by up(r0,w1,r1,w0,r0,w1), for 17N operations.
- R8: A read that returns something other than its expected value sets fail. The block also captures the address, the element index (0-based, in the order listed above) and the operation index (0-based within the element). Later miscompares in the same run change none of these.
- R9: With stop_on_fail high, the failing read is the last operation and done follows in the next cycle. With stop_on_fail low, the run goes on to the end of the algorithm.
- R10: With ret_en high, a gap of max(1, ret_cycles) cycles with no memory access follows element 0 and another follows element 1. With ret_en low there is no gap.
- R11: done is high for exactly one cycle, in the cycle after the last operation, and busy is low in that cycle. fail and the captured fields hold until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| algo_sel | input | 2 | Algorithm select, sampled at start |
| ret_en | input | 1 | Enables the retention gaps |
| ret_cycles | input | RET_W | Length of each retention gap in cycles |
| stop_on_fail | input | 1 | End the run at the first miscompare |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe; read data is returned in the same cycle |
| mem_wdata | output | 1 | RAM write data |
| mem_rdata | input | 1 | RAM read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A miscompare was seen in this run |
| fail_addr | output | AW | Address of the first miscompare |
| fail_elem | output | 3 | Element index of the first miscompare |
| fail_op | output | 3 | Operation index of the first miscompare |

## Verification
A corrupted element or operation index shows up at the memory port at once. The wrong data value or wrong strobe is driven in the very cycle it is issued, so a running signature of address, strobe and data departs from the expected sequence within one operation. A wrong address counter or direction shows the same way. A wrong end-of-element decision also changes the total run length, which the done pulse exposes exactly. A fault in the miscompare capture shows as a wrong first-failure triple, or as a fail flag that moves after it was set. An injected fault in the bench RAM makes this visible at done.

// File: rtl/march_pkg.sv
package march_pkg;

    localparam int MAX_OPS = 6;
    localparam int ELEM_W  = 3;
    localparam int OPI_W   = 3;

    typedef enum logic [1:0] {
        ALG_MATS_PLUS = 2'd0,
        ALG_MARCH_CM  = 2'd1,
        ALG_MARCH_A   = 2'd2,
        ALG_MARCH_B   = 2'd3
    } alg_e;

    // bit 1: read, bit 0: data value written or expected
    typedef enum logic [1:0] {
        OP_W0 = 2'b00,
        OP_W1 = 2'b01,
        OP_R0 = 2'b10,
        OP_R1 = 2'b11
    } op_e;

    typedef struct packed {
        logic                      down;
        logic [OPI_W-1:0]          nops;
        logic [MAX_OPS-1:0][1:0]   ops;
    } elem_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } seq_st_e;

    function automatic elem_t mk(logic down, int n,
                                 op_e o0, op_e o1 = OP_W0, op_e o2 = OP_W0,
                                 op_e o3 = OP_W0, op_e o4 = OP_W0, op_e o5 = OP_W0);
        elem_t e;
        e.down   = down;
        e.nops   = OPI_W'(n);
        e.ops[0] = o0;
        e.ops[1] = o1;
        e.ops[2] = o2;
        e.ops[3] = o3;
        e.ops[4] = o4;
        e.ops[5] = o5;
        return e;
    endfunction

    // Elements shared by both March A and March B apart from element 1
    function automatic elem_t march_ab_tail(logic [ELEM_W-1:0] i);
        case (i)
            3'd0:    return mk(1'b0, 1, OP_W0);
            3'd2:    return mk(1'b0, 3, OP_R1, OP_W0, OP_W1);
            3'd3:    return mk(1'b1, 4, OP_R1, OP_W0, OP_W1, OP_W0);
            3'd4:    return mk(1'b1, 3, OP_R0, OP_W1, OP_W0);
            default: return '0;
        endcase
    endfunction

    function automatic elem_t elem_of(alg_e a, logic [ELEM_W-1:0] i);
        case (a)
            ALG_MATS_PLUS: begin
                case (i)
                    3'd0:    return mk(1'b0, 1, OP_W0);
                    3'd1:    return mk(1'b0, 2, OP_R0, OP_W1);
                    3'd2:    return mk(1'b1, 2, OP_R1, OP_W0);
                    default: return '0;
                endcase
            end
            ALG_MARCH_CM: begin
                case (i)
                    3'd0:    return mk(1'b0, 1, OP_W0);
                    3'd1:    return mk(1'b0, 2, OP_R0, OP_W1);
                    3'd2:    return mk(1'b0, 2, OP_R1, OP_W0);
                    3'd3:    return mk(1'b1, 2, OP_R0, OP_W1);
                    3'd4:    return mk(1'b1, 2, OP_R1, OP_W0);
                    3'd5:    return mk(1'b0, 1, OP_R0);
                    default: return '0;
                endcase
            end
            ALG_MARCH_A: begin
                if (i == 3'd1) return mk(1'b0, 4, OP_R0, OP_W1, OP_W0, OP_W1);
                return march_ab_tail(i);
            end
            default: begin
                if (i == 3'd1) return mk(1'b0, 6, OP_R0, OP_W1, OP_R1, OP_W0, OP_R0, OP_W1);
                return march_ab_tail(i);
            end
        endcase
    endfunction

    function automatic logic [ELEM_W-1:0] last_elem(alg_e a);
        case (a)
            ALG_MATS_PLUS: return 3'd2;
            ALG_MARCH_CM:  return 3'd5;
            default:       return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          dir_load,
    input  logic          dir_cur,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] ADDR_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= dir_load ? ADDR_TOP : '0;
        end else if (step) begin
            addr <= dir_cur ? addr - AW'(1) : addr + AW'(1);
        end
    end

    assign at_end = dir_cur ? (addr == '0) : (addr == ADDR_TOP);

endmodule

// File: rtl/march_fail_log.sv
module march_fail_log #(
    parameter int AW = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic                          chk,
    input  logic                          exp_bit,
    input  logic                          rdata,
    input  logic [AW-1:0]                 addr,
    input  logic [march_pkg::ELEM_W-1:0]  elem,
    input  logic [march_pkg::OPI_W-1:0]   op,
    output logic                          miss,
    output logic                          fail,
    output logic [AW-1:0]                 fail_addr,
    output logic [march_pkg::ELEM_W-1:0]  fail_elem,
    output logic [march_pkg::OPI_W-1:0]   fail_op
);
    assign miss = chk && (rdata != exp_bit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
        end else if (miss && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_elem <= elem;
            fail_op   <= op;
        end
    end

endmodule

// File: rtl/march_seq.sv
module march_seq
    import march_pkg::*;
#(
    parameter int RET_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  alg_e              alg_in,
    input  logic              ret_en,
    input  logic [RET_W-1:0]  ret_cycles,
    input  logic              stop_on_fail,
    input  logic              miss,
    input  logic              at_end,
    output logic              op_valid,
    output logic [1:0]        op_code,
    output logic [ELEM_W-1:0] elem_idx,
    output logic [OPI_W-1:0]  op_idx,
    output logic              addr_load,
    output logic              addr_step,
    output logic              dir_load,
    output logic              dir_cur,
    output logic              busy,
    output logic              done,
    output logic              clear
);
    seq_st_e           st;
    alg_e              alg_q;
    logic [ELEM_W-1:0] elem_q;
    logic [OPI_W-1:0]  op_q;
    logic [RET_W-1:0]  gap_q;
    logic              done_q;

    elem_t cur_e;
    elem_t nxt_e;
    logic  op_last;
    logic  elem_last;
    logic  gap_after;
    logic  stop_hit;
    logic  gap_over;
    logic  idle_go;

    assign cur_e     = elem_of(alg_q, elem_q);
    assign nxt_e     = elem_of(alg_q, elem_q + ELEM_W'(1));
    assign op_last   = (op_q == cur_e.nops - OPI_W'(1));
    assign elem_last = (elem_q == last_elem(alg_q));
    assign gap_after = ret_en && (elem_q < ELEM_W'(2));
    assign stop_hit  = miss && stop_on_fail;
    assign gap_over  = (gap_q <= RET_W'(1));
    assign idle_go   = (st == ST_IDLE) && start;

    always_comb begin
        op_code = 2'b00;
        for (int k = 0; k < MAX_OPS; k++) begin
            if (op_q == OPI_W'(k)) op_code = cur_e.ops[k];
        end
    end

    assign op_valid  = (st == ST_RUN);
    assign elem_idx  = elem_q;
    assign op_idx    = op_q;
    assign dir_cur   = cur_e.down;
    assign dir_load  = (st == ST_IDLE) ? elem_of(alg_in, '0).down : nxt_e.down;
    assign addr_step = (st == ST_RUN) && !stop_hit && op_last && !at_end;
    assign addr_load = idle_go
                     || ((st == ST_RUN) && !stop_hit && op_last && at_end && !elem_last && !gap_after)
                     || ((st == ST_GAP) && gap_over);
    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign clear     = idle_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            alg_q  <= ALG_MATS_PLUS;
            elem_q <= '0;
            op_q   <= '0;
            gap_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        alg_q  <= alg_in;
                        elem_q <= '0;
                        op_q   <= '0;
                        st     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (stop_hit) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (op_last) begin
                        op_q <= '0;
                        if (at_end) begin
                            if (elem_last) begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end else if (gap_after) begin
                                st    <= ST_GAP;
                                gap_q <= ret_cycles;
                            end else begin
                                elem_q <= elem_q + ELEM_W'(1);
                            end
                        end
                    end else begin
                        op_q <= op_q + OPI_W'(1);
                    end
                end
                ST_GAP: begin
                    if (gap_over) begin
                        st     <= ST_RUN;
                        elem_q <= elem_q + ELEM_W'(1);
                    end else begin
                        gap_q <= gap_q - RET_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int AW    = 4,
    parameter int RET_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        algo_sel,
    input  logic              ret_en,
    input  logic [RET_W-1:0]  ret_cycles,
    input  logic              stop_on_fail,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_wdata,
    input  logic              mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [OPI_W-1:0]  fail_op
);
    logic              op_valid;
    logic [1:0]        op_code;
    logic [ELEM_W-1:0] elem_idx;
    logic [OPI_W-1:0]  op_idx;
    logic              addr_load;
    logic              addr_step;
    logic              dir_load;
    logic              dir_cur;
    logic              at_end;
    logic              miss;
    logic              clear;

    march_seq #(.RET_W(RET_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .alg_in       (alg_e'(algo_sel)),
        .ret_en       (ret_en),
        .ret_cycles   (ret_cycles),
        .stop_on_fail (stop_on_fail),
        .miss         (miss),
        .at_end       (at_end),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .elem_idx     (elem_idx),
        .op_idx       (op_idx),
        .addr_load    (addr_load),
        .addr_step    (addr_step),
        .dir_load     (dir_load),
        .dir_cur      (dir_cur),
        .busy         (busy),
        .done         (done),
        .clear        (clear)
    );

    march_addr_gen #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .step     (addr_step),
        .dir_load (dir_load),
        .dir_cur  (dir_cur),
        .addr     (mem_addr),
        .at_end   (at_end)
    );

    assign mem_we    = op_valid && !op_code[1];
    assign mem_re    = op_valid &&  op_code[1];
    assign mem_wdata = op_valid &&  op_code[0];

    march_fail_log #(.AW(AW)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .chk       (mem_re),
        .exp_bit   (op_code[0]),
        .rdata     (mem_rdata),
        .addr      (mem_addr),
        .elem      (elem_idx),
        .op        (op_idx),
        .miss      (miss),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_op   (fail_op)
    );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          mem_we,
    input logic          mem_re,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr
);
    a_r3_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !(start && !busy)) |=> fail);

    a_r8_fail_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (fail && !(start && !busy)) |=> $stable(fail_addr));

endmodule

bind march_bist march_bist_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr)
);

// File: tb/march_bist_bench.sv
module march_bist_bench;
    localparam int AW    = 4;
    localparam int N     = 1 << AW;
    localparam int RET_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       algo_sel = 2'd0;
    logic             ret_en = 1'b0;
    logic [RET_W-1:0] ret_cycles = '0;
    logic             stop_on_fail = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic             mem_we, mem_re, mem_wdata, mem_rdata;
    logic             busy, done, fail;
    logic [AW-1:0]    fail_addr;
    logic [2:0]       fail_elem, fail_op;

    march_bist #(.AW(AW), .RET_W(RET_W)) u_march_bist (
        .clk(clk), .rst(rst), .start(start), .algo_sel(algo_sel),
        .ret_en(ret_en), .ret_cycles(ret_cycles), .stop_on_fail(stop_on_fail),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_op(fail_op)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // RAM model with one optional fault: 1 stuck-at, 2 no 1->0, 3 no 0->1
    logic ram [N];
    logic clr_ram = 1'b0;
    int   ftype = 0;
    int   faddr = 0;
    logic fval  = 1'b0;

    function automatic bit blocked(int ft, int fa, int ad, logic old_v, logic new_v);
        if (ad != fa) return 1'b0;
        if (ft == 1) return 1'b1;
        if (ft == 2) return old_v && !new_v;
        if (ft == 3) return !old_v && new_v;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (clr_ram) begin
            for (int i = 0; i < N; i++) ram[i] <= 1'b0;
        end else if (mem_we) begin
            if (!blocked(ftype, faddr, int'(mem_addr), ram[mem_addr], mem_wdata))
                ram[mem_addr] <= mem_wdata;
        end
    end

    assign mem_rdata = (ftype == 1 && int'(mem_addr) == faddr) ? fval : ram[mem_addr];

    function automatic int unsigned hmix(int unsigned h, int ad, bit we, bit d);
        return (h * 33) ^ ((ad << 2) | (int'(we) << 1) | int'(d));
    endfunction

    // Monitor of the access stream
    bit          mon_en = 1'b0;
    int          acc_cnt = 0;
    int unsigned acc_hash = 0;
    always @(negedge clk) begin
        if (mon_en && (mem_we || mem_re)) begin
            acc_cnt++;
            acc_hash = hmix(acc_hash, int'(mem_addr), mem_we, mem_we ? mem_wdata : 1'b0);
        end
    end

    // Algorithm definitions: direction char, then (r|w)(0|1) pairs
    function automatic string spec(int a, int e);
        case (a)
            0: case (e)
                0: return "uw0";
                1: return "ur0w1";
                2: return "dr1w0";
                default: return "";
            endcase
            1: case (e)
                0: return "uw0";
                1: return "ur0w1";
                2: return "ur1w0";
                3: return "dr0w1";
                4: return "dr1w0";
                5: return "ur0";
                default: return "";
            endcase
            default: case (e)
                0: return "uw0";
                1: return (a == 3) ? "ur0w1r1w0r0w1" : "ur0w1w0w1";
                2: return "ur1w0w1";
                3: return "dr1w0w1w0";
                4: return "dr0w1w0";
                default: return "";
            endcase
        endcase
    endfunction

    int          exp_cyc, exp_acc, exp_faddr, exp_felem, exp_fop;
    bit          exp_fail;
    int unsigned exp_hash;

    task automatic ref_run(int a, bit ren, int rc, bit stp);
        logic  m [N];
        int    cyc;
        bit    stop_now;
        string s;
        int    nops, ad;
        bit    rd;
        logic  v, got;
        cyc = 0; stop_now = 0;
        exp_fail = 0; exp_faddr = 0; exp_felem = 0; exp_fop = 0;
        exp_acc = 0; exp_hash = 0;
        for (int i = 0; i < N; i++) m[i] = 1'b0;
        for (int e = 0; e < 6 && !stop_now; e++) begin
            s = spec(a, e);
            if (s.len() == 0) break;
            nops = (s.len() - 1) / 2;
            for (int k = 0; k < N && !stop_now; k++) begin
                ad = (s[0] == "d") ? N - 1 - k : k;
                for (int o = 0; o < nops && !stop_now; o++) begin
                    rd = (s[1 + 2 * o] == "r");
                    v  = (s[2 + 2 * o] == "1");
                    cyc++;
                    exp_acc++;
                    exp_hash = hmix(exp_hash, ad, !rd, rd ? 1'b0 : v);
                    if (rd) begin
                        got = (ftype == 1 && ad == faddr) ? fval : m[ad];
                        if (got !== v && !exp_fail) begin
                            exp_fail = 1; exp_faddr = ad; exp_felem = e; exp_fop = o;
                            if (stp) stop_now = 1;
                        end
                    end else if (!blocked(ftype, faddr, ad, m[ad], v)) begin
                        m[ad] = v;
                    end
                end
            end
            if (!stop_now && ren && e < 2) cyc += (rc < 1) ? 1 : rc;
        end
        exp_cyc = cyc + 1;
    endtask

    task automatic chk(string req, string what, int act, int expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic string alg_tag(int a);
        case (a)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_test(int a, bit ren, int rc, bit stp, int ft, int fa, logic fv, bit poke);
        int    cnt;
        string ctag;
        @(negedge clk);
        algo_sel = 2'(a); ret_en = ren; ret_cycles = RET_W'(rc); stop_on_fail = stp;
        ftype = ft; faddr = fa; fval = fv; clr_ram = 1'b1;
        @(negedge clk);
        clr_ram = 1'b0;
        ref_run(a, ren, rc, stp);
        acc_cnt = 0; acc_hash = 0; mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk("R2", "busy after start", int'(busy), 1);
        while (!done && cnt < 4000) begin
            @(negedge clk);
            cnt++;
            start = (poke && cnt == 4);
        end
        start = 1'b0;
        if (cnt >= 4000) chk("R11", "watchdog done seen", 0, 1);
        ctag = poke ? "R2" : ren ? "R10" : (stp && exp_fail) ? "R9" : alg_tag(a);
        chk(ctag, "cycles to done", cnt, exp_cyc);
        chk("R3", "access count", acc_cnt, exp_acc);
        chk("R3", "access signature", int'(acc_hash), int'(exp_hash));
        chk("R8", "fail flag", int'(fail), int'(exp_fail));
        if (exp_fail) begin
            chk("R8", "fail address", int'(fail_addr), exp_faddr);
            chk("R8", "fail element", int'(fail_elem), exp_felem);
            chk("R8", "fail op", int'(fail_op), exp_fop);
        end
        chk("R11", "busy low at done", int'(busy), 0);
        @(negedge clk);
        chk("R11", "done one cycle", int'(done), 0);
        chk("R11", "fail holds", int'(fail), int'(exp_fail));
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: got 0 runs finished expected all");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "fail after reset", int'(fail), 0);
        chk("R1", "no access after reset", int'(mem_we | mem_re), 0);

        run_test(0, 0, 0, 0, 0, 0, 1'b0, 0);   // R4 clean MATS+
        run_test(1, 0, 0, 0, 0, 0, 1'b0, 0);   // R5 clean March C-
        run_test(2, 0, 0, 0, 0, 0, 1'b0, 0);   // R6 clean March A
        run_test(3, 0, 0, 0, 0, 0, 1'b0, 0);   // R7 clean March B
        run_test(0, 0, 0, 0, 2, 5, 1'b0, 0);   // R8 down-transition escapes MATS+
        run_test(1, 0, 0, 0, 2, 5, 1'b0, 0);   // R8 caught by March C- element 3
        run_test(3, 0, 0, 1, 1, 0, 1'b1, 0);   // R9 stuck-at-1, stop on first read
        run_test(2, 0, 0, 0, 1, 15, 1'b0, 0);  // R9 stuck-at-0, continue to end
        run_test(0, 0, 0, 0, 3, 9, 1'b0, 0);   // R8 up-transition fault
        run_test(1, 1, 0, 0, 0, 0, 1'b0, 0);   // R10 zero gap length
        run_test(0, 1, 7, 0, 0, 0, 1'b0, 0);   // R10 seven-cycle gaps
        run_test(2, 0, 0, 0, 0, 0, 1'b0, 1);   // R2 start while busy

        for (int t = 0; t < 30; t++) begin
            int a, ft, fa, rc;
            bit ren, stp;
            logic fv;
            a   = int'($urandom % 4);
            ft  = int'($urandom % 4);
            fa  = int'($urandom % N);
            fv  = 1'($urandom % 2);
            ren = 1'($urandom % 2);
            rc  = int'($urandom % 12);
            stp = 1'($urandom % 2);
            run_test(a, ren, rc, stp, ft, fa, fv, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule